// File: doc/BRIEF.md
# Reduced-Instruction Boundary-Scan Test Port Controller

This block is the serial test port controller that sits between the four test pins and a boundary-scan chain that is built elsewhere. A mode-select line, sampled on each rising test-clock edge, steps a sixteen-state controller. That controller moves serial data through one of three places: a 3-bit instruction register, a 1-bit bypass register, or the external chain. The chain's serial output comes back into the block on `chainSo`. The block does not contain the boundary cells. It drives their control strobes instead: capture, shift, update, the combined data-register clock, a shift-select and a mode line.

The controller decodes only three instructions. The all-zeros code drives the pins from the chain. Code `100` samples the pins into the chain. Code `111`, and every code that is not decoded, routes data through the bypass bit. An active-low enable keeps the whole port inert. While the enable is high, the controller sits in its reset state and the serial output floats.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While `enableN` is high, the controller is held in its reset state asynchronously. `tdoEn` is 0, `tdo` is high-Z, the chain strobes `drCapture`, `drShift`, `drUpdate` and `drClock` are 0, `drShiftSel` is 1 and `drMode` is 1, whatever `tms` does.
- R2: State changes follow the standard sixteen-state test port diagram and depend only on `tms` at each rising `tck`. From any state, five rising edges with `tms`=1 reach the reset state.
- R3: `tdo` and `tdoEn` change only on the falling edge of `tck`. `tdoEn` is 1 only while the controller is in Shift-IR or Shift-DR. At all other times `tdo` is high-Z.
- R4: The instruction register is 3 bits wide. `tdi` enters at its MSB and `tdo` leaves from its LSB. In Capture-IR the instruction shifter loads `001`, so the first bits shifted out are 1, then 0, then 0.
- R5: Every rising edge spent in the reset state loads the instruction register with `111`, the bypass code.
- R6: With bypass selected, a single bit sits between `tdi` and `tdo`. That bit captures 0 in Capture-DR, and each bit shifted in appears on `tdo` after the next falling edge.
- R7: Code `000` selects the external chain and drives `drMode` to 0. In Shift-DR, `tdo` follows `chainSo`.
- R8: Code `100` selects the external chain with `drMode` at 1.
- R9: Any code other than `000` and `100` acts as bypass. It keeps `drMode` at 1 and keeps the chain strobes at 0.
- R10: When the chain is selected, `drCapture` is 1 in Capture-DR, `drShift` is 1 in Shift-DR, and `drClock` is 1 in both of those states. `drUpdate` is 1 only in Update-DR.
- R11: `drShiftSel` is 0 only in Capture-DR, for any instruction.
- R12: The active instruction, and so `drMode`, changes only on the rising edge taken in Update-IR, or in the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| enableN | input | 1 | Active-low port enable; high holds the controller in reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| chainSo | input | 1 | Serial output returned from the external boundary chain |
| tdo | output | 1 | Serial data out, changes on falling `tck`, high-Z when idle |
| tdoEn | output | 1 | Output enable for `tdo` |
| drCapture | output | 1 | Chain capture strobe |
| drShift | output | 1 | Chain shift strobe |
| drUpdate | output | 1 | Chain update strobe |
| drClock | output | 1 | Chain clock enable (capture or shift) |
| drShiftSel | output | 1 | Chain shift/parallel select, 0 only in Capture-DR |
| drMode | output | 1 | Chain output mode, 0 only for the drive-pins instruction |

## Verification
The data-register path is exercised under each instruction class: the drive-pins code, the sample code, the bypass code and the undecoded code `010`. The shift patterns and chain return values are chosen so that each path gives a different result. The chain path makes `tdo` copy `chainSo`. The bypass path gives a leading 0 followed by `tdi` delayed by one bit. A strobe that fired under the wrong instruction would show up at the ports. Separate sequences check four more behaviours. Reading back the captured instruction pattern exposes the shift direction. Passing through Pause-DR checks the output-enable window. A run of ones on `tms` after loading the drive-pins code must restore bypass. Dropping the enable in the middle of a shift must float `tdo` at once.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  // strobes from control to datapath, one per active state
  typedef struct packed {
    logic inReset;
    logic capIr;
    logic shIr;
    logic updIr;
    logic capDr;
    logic shDr;
    logic updDr;
  } tapCtl_t;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic    tck,
  input  logic    enableN,
  input  logic    tms,
  output tapCtl_t ctl
);

  tapState_e state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      default:   nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or posedge enableN) begin
    if (enableN) state <= ST_RESET;
    else         state <= nextState;
  end

  always_comb begin
    ctl.inReset = (state == ST_RESET);
    ctl.capIr   = (state == ST_CAP_IR);
    ctl.shIr    = (state == ST_SH_IR);
    ctl.updIr   = (state == ST_UPD_IR);
    ctl.capDr   = (state == ST_CAP_DR);
    ctl.shDr    = (state == ST_SH_DR);
    ctl.updDr   = (state == ST_UPD_DR);
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (enableN)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
      |-> ctl.inReset); // R2

  AST_CAPDR_TO_SHIFT: assert property (@(posedge tck) disable iff (enableN)
    (ctl.capDr && !tms) |=> ctl.shDr); // R2

  AST_SHIR_EXIT: assert property (@(posedge tck) disable iff (enableN)
    (ctl.shIr && tms) |=> !ctl.shIr && !ctl.updIr); // R2

endmodule

// File: rtl/scan_tap_datapath.sv
module scan_tap_datapath
  import scan_tap_pkg::*;
(
  input  logic    tck,
  input  logic    enableN,
  input  logic    tdi,
  input  logic    chainSo,
  input  tapCtl_t ctl,
  output logic    tdo,
  output logic    tdoEn,
  output logic    drCapture,
  output logic    drShift,
  output logic    drUpdate,
  output logic    drClock,
  output logic    drShiftSel,
  output logic    drMode
);

  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irReg;
  logic            bypassQ;
  logic            chainSel;
  logic            tdoBit;
  logic            tdoQ;
  logic            tdoEnQ;

  // instruction shifter: tdi in at MSB, out at LSB
  always_ff @(posedge tck or posedge enableN) begin
    if (enableN)        irShift <= IR_CAPTURE;
    else if (ctl.capIr) irShift <= IR_CAPTURE;
    else if (ctl.shIr)  irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // active instruction
  always_ff @(posedge tck or posedge enableN) begin
    if (enableN)          irReg <= OP_BYPASS;
    else if (ctl.inReset) irReg <= OP_BYPASS;
    else if (ctl.updIr)   irReg <= irShift;
  end

  // decode: anything not listed falls back to bypass
  always_comb begin
    unique case (irReg)
      OP_EXTEST: begin chainSel = 1'b1; drMode = 1'b0; end
      OP_SAMPLE: begin chainSel = 1'b1; drMode = 1'b1; end
      default:   begin chainSel = 1'b0; drMode = 1'b1; end
    endcase
  end

  always_ff @(posedge tck or posedge enableN) begin
    if (enableN)        bypassQ <= 1'b0;
    else if (ctl.capDr) bypassQ <= 1'b0;
    else if (ctl.shDr)  bypassQ <= tdi;
  end

  assign tdoBit = ctl.shIr ? irShift[0] : (chainSel ? chainSo : bypassQ);

  // output stage on falling edge
  always_ff @(negedge tck or posedge enableN) begin
    if (enableN) begin
      tdoQ   <= 1'b0;
      tdoEnQ <= 1'b0;
    end else begin
      tdoQ   <= tdoBit;
      tdoEnQ <= ctl.shIr | ctl.shDr;
    end
  end

  assign tdoEn = tdoEnQ;
  assign tdo   = tdoEnQ ? tdoQ : 1'bz;

  assign drCapture  = chainSel & ctl.capDr;
  assign drShift    = chainSel & ctl.shDr;
  assign drUpdate   = chainSel & ctl.updDr;
  assign drClock    = chainSel & (ctl.capDr | ctl.shDr);
  assign drShiftSel = ~ctl.capDr;

  AST_TDOEN_SHIFT: assert property (@(posedge tck) disable iff (enableN)
    tdoEnQ == (ctl.shIr | ctl.shDr)); // R3

  AST_IR_RESET: assert property (@(posedge tck) disable iff (enableN)
    ctl.inReset |=> (irReg == OP_BYPASS)); // R5

  AST_BYPASS_CAPTURE: assert property (@(posedge tck) disable iff (enableN)
    ctl.capDr |=> (bypassQ == 1'b0)); // R6

  AST_IR_HOLD: assert property (@(posedge tck) disable iff (enableN)
    (!ctl.updIr && !ctl.inReset) |=> $stable(irReg)); // R12

  AST_UPDATE_NOT_CLOCK: assert property (@(posedge tck) disable iff (enableN)
    !(drUpdate && drClock)); // R10

  AST_SHIFTSEL_CLOCK: assert property (@(posedge tck) disable iff (enableN)
    (!drShiftSel && chainSel) |-> drClock); // R11

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic tck,
  input  logic enableN,
  input  logic tms,
  input  logic tdi,
  input  logic chainSo,
  output logic tdo,
  output logic tdoEn,
  output logic drCapture,
  output logic drShift,
  output logic drUpdate,
  output logic drClock,
  output logic drShiftSel,
  output logic drMode
);

  tapCtl_t ctl;

  scan_tap_fsm u_fsm (
    .tck     (tck),
    .enableN (enableN),
    .tms     (tms),
    .ctl     (ctl)
  );

  scan_tap_datapath u_dp (
    .tck        (tck),
    .enableN    (enableN),
    .tdi        (tdi),
    .chainSo    (chainSo),
    .ctl        (ctl),
    .tdo        (tdo),
    .tdoEn      (tdoEn),
    .drCapture  (drCapture),
    .drShift    (drShift),
    .drUpdate   (drUpdate),
    .drClock    (drClock),
    .drShiftSel (drShiftSel),
    .drMode     (drMode)
  );

endmodule

// File: tb/scan_tap_ctrl_tb.sv
`timescale 1ns/1ps
module scan_tap_ctrl_tb;

  logic tck = 1'b0;
  logic enableN, tms, tdi, chainSo;
  logic tdo, tdoEn, drCapture, drShift, drUpdate, drClock, drShiftSel, drMode;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 tck = ~tck;

  scan_tap_ctrl u_dut (
    .tck(tck), .enableN(enableN), .tms(tms), .tdi(tdi), .chainSo(chainSo),
    .tdo(tdo), .tdoEn(tdoEn), .drCapture(drCapture), .drShift(drShift),
    .drUpdate(drUpdate), .drClock(drClock), .drShiftSel(drShiftSel), .drMode(drMode)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic act, input logic exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic chkBit(input logic act, input logic exp, input string req, input string what);
    chk(act === exp, req, what, act, exp);
  endtask

  // drive, take one rising edge, then settle after the falling edge
  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic loadIr(input logic [2:0] code, input logic modeBefore);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) step(i == 2, code[i]);
    chkBit(drMode, modeBefore, "R12", "mode before Update-IR");
    step(1, 0);
    chkBit(drMode, modeBefore, "R12", "mode while in Update-IR");
    step(0, 0);
  endtask

  task automatic testDisabled;
    step(0, 0); step(1, 0); step(0, 0); step(0, 0);
    chkBit(tdoEn, 1'b0, "R1", "tdoEn disabled");
    chkBit(tdo, 1'bz, "R1", "tdo disabled");
    chkBit(drClock, 1'b0, "R1", "drClock disabled");
    chkBit(drShiftSel, 1'b1, "R1", "shiftSel disabled");
    chkBit(drMode, 1'b1, "R1", "mode disabled");
  endtask

  task automatic testIrCapture;
    enableN = 1'b0;
    step(0, 1);
    step(1, 1); step(1, 1); step(0, 1);
    chkBit(tdoEn, 1'b0, "R3", "tdoEn in Capture-IR");
    step(0, 1);
    chkBit(tdoEn, 1'b1, "R3", "tdoEn in Shift-IR");
    chkBit(tdo, 1'b1, "R4", "captured bit0");
    step(0, 1);
    chkBit(tdo, 1'b0, "R4", "captured bit1");
    step(0, 1);
    chkBit(tdo, 1'b0, "R4", "captured bit2");
    step(1, 1);
    chkBit(tdo, 1'bz, "R3", "tdo in Exit1-IR");
    step(1, 0); step(0, 0);
    chkBit(drMode, 1'b1, "R4", "reloaded 111 keeps mode");
  endtask

  task automatic testBypass(input string req);
    logic [3:0] pat = 4'b1101;
    step(1, 0); step(0, 0);
    chkBit(drShiftSel, 1'b0, "R11", "shiftSel in Capture-DR (bypass)");
    chkBit(drClock, 1'b0, req, "no chain clock under bypass");
    chkBit(drCapture, 1'b0, req, "no chain capture under bypass");
    step(0, 0);
    chkBit(tdo, 1'b0, "R6", "bypass captured 0");
    chkBit(drShift, 1'b0, req, "no chain shift under bypass");
    for (int i = 0; i < 4; i++) begin
      step(0, pat[i]);
      chkBit(tdo, pat[i], "R6", "bypass echo");
    end
    step(1, 0); step(1, 0);
    chkBit(drUpdate, 1'b0, req, "no chain update under bypass");
    step(0, 0);
  endtask

  task automatic testExtest;
    loadIr(3'b000, 1'b1);
    chkBit(drMode, 1'b0, "R7", "mode 0 for drive code");
    step(1, 0); step(0, 0);
    chkBit(drCapture, 1'b1, "R10", "capture strobe");
    chkBit(drClock, 1'b1, "R10", "clock in Capture-DR");
    chkBit(drShiftSel, 1'b0, "R11", "shiftSel in Capture-DR");
    chkBit(drShift, 1'b0, "R10", "no shift in Capture-DR");
    chainSo = 1'b1;
    step(0, 0);
    chkBit(tdo, 1'b1, "R7", "tdo follows chain (1)");
    chkBit(drShift, 1'b1, "R10", "shift strobe");
    chkBit(drClock, 1'b1, "R10", "clock in Shift-DR");
    chkBit(drShiftSel, 1'b1, "R11", "shiftSel in Shift-DR");
    chainSo = 1'b0;
    step(0, 0);
    chkBit(tdo, 1'b0, "R7", "tdo follows chain (0)");
    step(1, 0);
    chkBit(tdoEn, 1'b0, "R3", "tdoEn in Exit1-DR");
    chkBit(drClock, 1'b0, "R10", "clock off in Exit1-DR");
    step(0, 0);
    chkBit(tdo, 1'bz, "R3", "tdo in Pause-DR");
    chkBit(drClock, 1'b0, "R10", "clock off in Pause-DR");
    step(1, 0); step(0, 0);
    chkBit(tdoEn, 1'b1, "R2", "Exit2-DR back to Shift-DR");
    step(1, 0); step(1, 0);
    chkBit(drUpdate, 1'b1, "R10", "update strobe");
    chkBit(drClock, 1'b0, "R10", "clock off in Update-DR");
    step(0, 0);
    chkBit(drUpdate, 1'b0, "R10", "update off in idle");
  endtask

  task automatic testSample;
    loadIr(3'b100, 1'b0);
    chkBit(drMode, 1'b1, "R8", "mode 1 for sample code");
    step(1, 0); step(0, 0);
    chkBit(drCapture, 1'b1, "R8", "chain captures under sample");
    chainSo = 1'b1;
    step(0, 0);
    chkBit(tdo, 1'b1, "R8", "tdo from chain under sample");
    step(1, 0); step(1, 0); step(0, 0);
  endtask

  task automatic testReset;
    loadIr(3'b000, 1'b1);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(1, 0);
    chkBit(drMode, 1'b1, "R5", "reset state restores bypass");
    step(0, 0);
    step(1, 0); step(0, 0);
    chkBit(drClock, 1'b0, "R2", "five ones reached reset");
    step(1, 0); step(1, 0); step(0, 0);
  endtask

  task automatic testDisableMidShift;
    loadIr(3'b000, 1'b1);
    step(1, 0); step(0, 0); step(0, 0);
    chkBit(tdoEn, 1'b1, "R1", "enabled before drop");
    enableN = 1'b1;
    #1;
    chkBit(tdoEn, 1'b0, "R1", "tdoEn drops at once");
    chkBit(tdo, 1'bz, "R1", "tdo floats at once");
    chkBit(drMode, 1'b1, "R1", "mode back to 1");
    chkBit(drShift, 1'b0, "R1", "shift strobe off");
  endtask

  initial begin
    enableN = 1'b1; tms = 1'b1; tdi = 1'b0; chainSo = 1'b0;
    @(negedge tck); #1;
    testDisabled();
    testIrCapture();
    testBypass("R6");
    testExtest();
    testSample();
    loadIr(3'b010, 1'b1);
    chkBit(drMode, 1'b1, "R9", "undecoded keeps mode 1");
    testBypass("R9");
    testReset();
    testDisableMidShift();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule